// File: doc/BRIEF.md
# Channel Remapping Crossbar

This block sits between a multi-channel sample source and a set of per-channel outputs. Every output channel owns a select register that names the input channel it copies. Any mapping can be set up, including a permutation or one input fanned out to every output. A small write port loads the select registers one output at a time.

The wide N-to-1 selector behind each output is built as two levels. The first level is a row of small multiplexers, each covering a parameter-sized group of inputs. The second level picks one of their results. A parameter can place a register between the two levels to shorten the critical path, at the cost of one extra cycle of latency. A second parameter compiles the whole remap function out. In that case every output simply copies the input of the same index, and the select registers are not built.

Top module: `chan_remap_xbar`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_data` is all zeros until the first valid sample emerges. The select register of output i resets to i.
- R2: With `REMAP_EN=0`, output channel i (bits `[i*DW +: DW]`) carries input channel i, one cycle after a valid sample is presented. Select writes have no effect.
- R3: With `REMAP_EN=1`, a write with `cfg_we=1` stores `cfg_sel` into the select register of output `cfg_idx`. Output channel i then carries the input channel named by its select register. A sample sampled on a clock edge uses the select values stored before that edge.
- R4: Several outputs may name the same input, so one input can drive every output at once.
- R5: A select value equal to or above `NCH` routes input channel 0.
- R6: `out_valid` repeats `in_valid` after a latency of 1 cycle with `PIPE=0` and 2 cycles with `PIPE=1`. The data of that sample appears in the same cycle.
- R7: A write whose `cfg_idx` is equal to or above `NCH` changes no select register.
- R8: While no valid sample reaches the output stage, `out_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_data | input | NCH*DW | Input channels, channel k in bits [k*DW +: DW] |
| cfg_we | input | 1 | Select register write strobe |
| cfg_idx | input | SW | Output channel whose select is written |
| cfg_sel | input | SW | Input channel number to store |
| out_valid | output | 1 | Output sample valid |
| out_data | output | NCH*DW | Output channels, channel i in bits [i*DW +: DW] |

## Verification
The bench builds three copies with `NCH=6`, `DW=8` and `SUB=4`. Two copies have the remap enabled, one without and one with the intermediate register. The third copy has the remap compiled out. Six channels in groups of four leave the second first-level multiplexer only half filled. The 3-bit select field also reaches the values 6 and 7, so the fallback to input 0 and the ignored write to a missing output can both be exercised. Every input carries a distinct value per sample, so a wrong route, a wrong group or a wrong latency shows up as a mismatch.

// File: rtl/chan_remap_xbar.sv
module chan_remap_xbar #(
  parameter int NCH      = 8,
  parameter int DW       = 16,
  parameter int SUB      = 4,
  parameter bit PIPE     = 1'b0,
  parameter bit REMAP_EN = 1'b0,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_idx,
  input  logic [SW-1:0]     cfg_sel,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_data
);
  localparam int NG  = (NCH + SUB - 1) / SUB;
  localparam int LW  = (SUB > 1) ? $clog2(SUB) : 1;
  localparam int HW  = (NG > 1) ? $clog2(NG) : 1;
  localparam int LAT = PIPE ? 2 : 1;

  logic v_mid;

  if (PIPE) begin : g_vpipe
    always_ff @(posedge clk)
      if (!rst_n) v_mid <= 1'b0;
      else        v_mid <= in_valid;
  end else begin : g_vdirect
    assign v_mid = in_valid;
  end

  always_ff @(posedge clk)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v_mid;

  if (REMAP_EN) begin : g_remap
    logic [SW-1:0] sel_q [NCH];

    always_ff @(posedge clk)
      if (!rst_n) begin
        for (int i = 0; i < NCH; i++) sel_q[i] <= SW'(i);
      end else if (cfg_we && int'(cfg_idx) < NCH) begin
        sel_q[cfg_idx] <= cfg_sel;
      end

    // R3
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_idx) < NCH) |=> sel_q[$past(cfg_idx)] == $past(cfg_sel));

    for (genvar o = 0; o < NCH; o++) begin : g_out
      logic [SW-1:0] eff;
      logic [LW-1:0] lo;
      logic [HW-1:0] hi, hi_s;
      logic [DW-1:0] l1 [NG];
      logic [DW-1:0] l1_s [NG];
      logic [DW-1:0] l2, q;

      assign eff = (int'(sel_q[o]) < NCH) ? sel_q[o] : '0;
      assign lo  = LW'(int'(eff) % SUB);
      assign hi  = HW'(int'(eff) / SUB);

      for (genvar g = 0; g < NG; g++) begin : g_sub
        always_comb begin
          l1[g] = '0;
          for (int k = 0; k < SUB; k++)
            if (g * SUB + k < NCH && lo == LW'(k))
              l1[g] = in_data[((g * SUB + k) % NCH) * DW +: DW];
        end
      end

      if (PIPE) begin : g_reg
        always_ff @(posedge clk)
          if (!rst_n) begin
            hi_s <= '0;
            for (int g = 0; g < NG; g++) l1_s[g] <= '0;
          end else if (in_valid) begin
            hi_s <= hi;
            l1_s <= l1;
          end
      end else begin : g_wire
        assign hi_s = hi;
        assign l1_s = l1;
      end

      always_comb begin
        l2 = '0;
        for (int g = 0; g < NG; g++)
          if (hi_s == HW'(g)) l2 = l1_s[g];
      end

      always_ff @(posedge clk)
        if (!rst_n)     q <= '0;
        else if (v_mid) q <= l2;

      assign out_data[o*DW +: DW] = q;
    end
  end else begin : g_pass
    logic cfg_unused;
    assign cfg_unused = cfg_we ^ (^cfg_idx) ^ (^cfg_sel);

    if (PIPE) begin : g_reg
      logic [NCH*DW-1:0] mid;
      always_ff @(posedge clk)
        if (!rst_n)        mid <= '0;
        else if (in_valid) mid <= in_data;
      always_ff @(posedge clk)
        if (!rst_n)     out_data <= '0;
        else if (v_mid) out_data <= mid;
    end else begin : g_wire
      always_ff @(posedge clk)
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= in_data;
    end

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!PIPE && out_valid) |-> out_data == $past(in_data));
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, LAT));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(v_mid) |-> $stable(out_data));
endmodule

// File: tb/test_chan_remap_xbar.sv
`timescale 1ns/1ps
module test_chan_remap_xbar;
  localparam int NCH = 6, DW = 8, SW = 3, BW = NCH * DW;
  localparam logic [17:0] MAPS [6] = '{18'o543210, 18'o012345, 18'o222222,
                                        18'o555555, 18'o767676, 18'o041736};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, cfg_we = 1'b0;
  logic [BW-1:0] in_data = '0;
  logic [SW-1:0] cfg_idx = '0, cfg_sel = '0;
  logic v0, v1, v2;
  logic [BW-1:0] d0, d1, d2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chan_remap_xbar #(.NCH(NCH), .DW(DW), .SUB(4), .PIPE(1'b0), .REMAP_EN(1'b1)) i_chan_remap_xbar (
    .clk, .rst_n, .in_valid, .in_data, .cfg_we, .cfg_idx, .cfg_sel,
    .out_valid(v0), .out_data(d0));
  chan_remap_xbar #(.NCH(NCH), .DW(DW), .SUB(4), .PIPE(1'b1), .REMAP_EN(1'b1)) i_chan_remap_xbar_p (
    .clk, .rst_n, .in_valid, .in_data, .cfg_we, .cfg_idx, .cfg_sel,
    .out_valid(v1), .out_data(d1));
  chan_remap_xbar #(.NCH(NCH), .DW(DW), .SUB(4), .PIPE(1'b0), .REMAP_EN(1'b0)) i_chan_remap_xbar_d (
    .clk, .rst_n, .in_valid, .in_data, .cfg_we, .cfg_idx, .cfg_sel,
    .out_valid(v2), .out_data(d2));

  function automatic logic [DW-1:0] chval(int p, int k);
    return DW'(p * 7 + k * 32 + 1);
  endfunction

  function automatic logic [BW-1:0] frame(int p);
    logic [BW-1:0] f;
    for (int k = 0; k < NCH; k++) f[k*DW +: DW] = chval(p, k);
    return f;
  endfunction

  function automatic logic [BW-1:0] mapped(int p, logic [17:0] m);
    logic [BW-1:0] f;
    for (int o = 0; o < NCH; o++) begin
      int s = int'(m[o*3 +: 3]);
      f[o*DW +: DW] = chval(p, (s < NCH) ? s : 0);
    end
    return f;
  endfunction

  task automatic chk(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, int sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = SW'(idx); cfg_sel = SW'(sel);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_map(logic [17:0] m);
    for (int o = 0; o < NCH; o++) wr(o, int'(m[o*3 +: 3]));
  endtask

  task automatic send(int p, logic [17:0] m, string tag);
    logic [BW-1:0] e = mapped(p, m);
    @(negedge clk);
    in_valid = 1'b1; in_data = frame(p);
    @(negedge clk);
    in_valid = 1'b0; in_data = frame(p + 50);
    chk(v0 && d0 == e, {tag, " nopipe"}, d0, e);
    chk(v2 && d2 == frame(p), "R2 passthrough", d2, frame(p));
    chk(!v1, "R6 pipe latency early", BW'(v1), '0);
    @(negedge clk);
    chk(v1 && d1 == e, {tag, " pipe"}, d1, e);
    chk(!v0 && d0 == e, "R8 hold nopipe", d0, e);
    @(negedge clk);
    chk(!v1 && d1 == e, "R8 hold pipe", d1, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!v0 && !v1 && !v2 && d0 == '0 && d1 == '0 && d2 == '0, "R1 reset outputs", d0 | d1 | d2, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!v0 && !v1 && !v2, "R1 idle after reset", BW'({v0, v1, v2}), '0);
    send(3, MAPS[0], "R1 identity select");
    for (int e = 0; e < 6; e++) begin
      load_map(MAPS[e]);
      send(e + 10, MAPS[e], (e == 2 || e == 3) ? "R4 broadcast" : (e >= 4) ? "R5 out of range" : "R3 mapping");
    end
    load_map(MAPS[1]);
    wr(6, 2);
    wr(7, 4);
    send(40, MAPS[1], "R7 bad index ignored");
    @(negedge clk);
    in_valid = 1'b1; in_data = frame(60);
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_sel = 3'd4;
    @(negedge clk);
    cfg_we = 1'b0; in_data = frame(61);
    chk(d0 == mapped(60, MAPS[1]), "R3 old select at write edge", d0, mapped(60, MAPS[1]));
    @(negedge clk);
    in_valid = 1'b0;
    chk(d0 == mapped(61, 18'o012344), "R3 new select after write", d0, mapped(61, 18'o012344));
    chk(d1 == mapped(60, MAPS[1]), "R6 pipe keeps select of its sample", d1, mapped(60, MAPS[1]));
    @(negedge clk);
    chk(d1 == mapped(61, 18'o012344), "R6 pipe second sample", d1, mapped(61, 18'o012344));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule